// File: doc/BRIEF.md
# Windowed Extended Register Access Bridge

This block sits on the device side of a management register port and opens a large extended register space through two windows in the basic 32-entry register map. Register 13 is the control window. It holds a 5-bit device address that selects an extended bank, and a 2-bit function field that chooses what register 14 does. Register 14 is the address/data window. Depending on the function, it either loads the pointer into the selected bank or moves data to and from the register that pointer names. Three data functions differ in when the pointer steps forward: never, after every access, or after writes only.

A host runs a full access in four steps:
1. Write the device address to register 13 with the function set to address.
2. Write the extended register address to register 14.
3. Write register 13 again with the same device address and a data function.
4. Read or write register 14.

Each implemented device keeps its own pointer and its own small register file. Devices and registers that are not implemented read as zero and take no writes.

Top module: `xreg_bridge`

## Requirements
- R1: A synchronous reset clears the control register, every device pointer, every extended register and the read data output to zero.
- R2: A write to register 13 stores all 16 bits, and a read of register 13 returns the last value written. Bits [4:0] are the device address and bits [15:14] are the function.
- R3: With function 00 (address), a write to register 14 loads the pointer of the selected device, and a read of register 14 returns that pointer.
- R4: With function 01, reads and writes of register 14 reach the extended register that the pointer names, and the pointer does not change.
- R5: With function 10, the pointer steps by one after each read and after each write of register 14.
- R6: With function 11, the pointer steps by one after each write of register 14, and reads leave it unchanged.
- R7: The pointer wraps from 0xFFFF to 0x0000 when it steps.
- R8: Each implemented device (DEV_BASE to DEV_BASE+NUM_DEV-1) keeps its own pointer and registers. Loading or stepping one device's pointer leaves every other device unchanged.
- R9: Two kinds of access read as zero and change no state:
  - any register 14 access to an unimplemented device;
  - a data access whose pointer is at or above REG_DEPTH. Such a data access still steps the pointer by the function's rule.
- R10: Reads of basic registers other than 13 and 14 return zero, and writes to them change no state.
- R11: The read data output updates on the clock edge that samples the read strobe and holds its value otherwise. When the write enable and the read strobe are both high in the same cycle, the write is done and the read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write enable |
| regNum | input | 5 | Basic register number |
| wrData | input | 16 | Write data |
| rdEn | input | 1 | Read strobe |
| rdData | output | 16 | Read data, registered |

## Verification
The bench builds the block with its defaults: devices 30 and 31 implemented, and eight extended registers per device. With these values both ends of the device span can be tested against an unimplemented device 0. Pointer 8 is the first address outside a register file. Pointer 0xFFFF is both out of range and the wrap point, and its truncated index (7) lets the bench confirm that an out-of-range write does not alias onto a real register.

// File: rtl/xreg_pkg.sv
package xreg_pkg;
  localparam logic [4:0] CTRL_REG = 5'd13;
  localparam logic [4:0] WIN_REG  = 5'd14;

  localparam logic [1:0] FN_ADDR   = 2'b00;
  localparam logic [1:0] FN_NOINC  = 2'b01;
  localparam logic [1:0] FN_INC_RW = 2'b10;
  localparam logic [1:0] FN_INC_W  = 2'b11;

  typedef enum logic [2:0] {
    RD_NONE = 3'd0,
    RD_ZERO = 3'd1,
    RD_CTRL = 3'd2,
    RD_PTR  = 3'd3,
    RD_DATA = 3'd4
  } rdSelT;

  typedef struct packed {
    logic       ptrLoad;
    logic       dataWr;
    logic       ptrIncr;
    rdSelT      rdSel;
    logic       devHit;
    logic [4:0] devIdx;
  } strobeT;
endpackage

// File: rtl/xreg_ctrl.sv
module xreg_ctrl
  import xreg_pkg::*;
#(
  parameter int DEV_BASE = 30,
  parameter int NUM_DEV  = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic [4:0]  regNum,
  input  logic [15:0] wrData,
  input  logic        rdEn,
  output strobeT      strb,
  output logic [15:0] ctrlVal
);
  localparam logic [5:0] DEV_LO = 6'(DEV_BASE);
  localparam logic [5:0] DEV_HI = 6'(DEV_BASE + NUM_DEV);

  logic [15:0] ctrlQ;
  logic [1:0]  fn;
  logic [4:0]  dev;
  logic        hit;

  always_ff @(posedge clk) begin
    if (rst) ctrlQ <= '0;
    else if (wrEn && regNum == CTRL_REG) ctrlQ <= wrData;
  end

  assign fn      = ctrlQ[15:14];
  assign dev     = ctrlQ[4:0];
  assign hit     = ({1'b0, dev} >= DEV_LO) && ({1'b0, dev} < DEV_HI);
  assign ctrlVal = ctrlQ;

  always_comb begin
    strb        = '0;
    strb.rdSel  = RD_NONE;
    strb.devHit = hit;
    strb.devIdx = dev - 5'(DEV_BASE);
    if (wrEn) begin
      if (regNum == WIN_REG && hit) begin
        if (fn == FN_ADDR) begin
          strb.ptrLoad = 1'b1;
        end else begin
          strb.dataWr  = 1'b1;
          strb.ptrIncr = fn[1];
        end
      end
    end else if (rdEn) begin
      if (regNum == CTRL_REG) begin
        strb.rdSel = RD_CTRL;
      end else if (regNum == WIN_REG) begin
        if (fn == FN_ADDR) begin
          strb.rdSel = hit ? RD_PTR : RD_ZERO;
        end else begin
          strb.rdSel   = RD_DATA;
          strb.ptrIncr = hit && (fn == FN_INC_RW);
        end
      end else begin
        strb.rdSel = RD_ZERO;
      end
    end
  end
endmodule

// File: rtl/xreg_datapath.sv
module xreg_datapath
  import xreg_pkg::*;
#(
  parameter int NUM_DEV   = 2,
  parameter int REG_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  strobeT      strb,
  input  logic [15:0] wrData,
  input  logic [15:0] ctrlVal,
  output logic [15:0] rdData,
  output logic [15:0] curPtr
);
  localparam int IDX_W = (REG_DEPTH > 1) ? $clog2(REG_DEPTH) : 1;
  localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam logic [16:0] DEPTH_L = 17'(REG_DEPTH);

  logic [NUM_DEV-1:0][15:0] ptrAll;
  logic [NUM_DEV-1:0][15:0] wordAll;
  logic [DEV_W-1:0]         devSel;
  logic [15:0]              curWord;

  for (genvar d = 0; d < NUM_DEV; d++) begin : gDev
    logic        sel;
    logic        inRange;
    logic [15:0] ptr;
    logic [15:0] mem [REG_DEPTH];

    assign sel     = strb.devHit && (strb.devIdx == 5'(d));
    assign inRange = {1'b0, ptr} < DEPTH_L;

    always_ff @(posedge clk) begin
      if (rst) ptr <= '0;
      else if (sel && strb.ptrLoad) ptr <= wrData;
      else if (sel && strb.ptrIncr) ptr <= ptr + 16'd1;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < REG_DEPTH; i++) mem[i] <= '0;
      end else if (sel && strb.dataWr && inRange) begin
        mem[ptr[IDX_W-1:0]] <= wrData;
      end
    end

    assign ptrAll[d]  = ptr;
    assign wordAll[d] = inRange ? mem[ptr[IDX_W-1:0]] : '0;
  end

  assign devSel  = strb.devIdx[DEV_W-1:0];
  assign curPtr  = strb.devHit ? ptrAll[devSel] : '0;
  assign curWord = strb.devHit ? wordAll[devSel] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
    end else begin
      case (strb.rdSel)
        RD_ZERO: rdData <= '0;
        RD_CTRL: rdData <= ctrlVal;
        RD_PTR:  rdData <= curPtr;
        RD_DATA: rdData <= curWord;
        default: rdData <= rdData;
      endcase
    end
  end
endmodule

// File: rtl/xreg_bridge.sv
module xreg_bridge
  import xreg_pkg::*;
#(
  parameter int DEV_BASE  = 30,
  parameter int NUM_DEV   = 2,
  parameter int REG_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic [4:0]  regNum,
  input  logic [15:0] wrData,
  input  logic        rdEn,
  output logic [15:0] rdData
);
  strobeT      strb;
  logic [15:0] ctrlVal;
  logic [15:0] curPtr;

  xreg_ctrl #(.DEV_BASE(DEV_BASE), .NUM_DEV(NUM_DEV)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .regNum(regNum), .wrData(wrData),
    .rdEn(rdEn), .strb(strb), .ctrlVal(ctrlVal)
  );

  xreg_datapath #(.NUM_DEV(NUM_DEV), .REG_DEPTH(REG_DEPTH)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .wrData(wrData), .ctrlVal(ctrlVal),
    .rdData(rdData), .curPtr(curPtr)
  );
endmodule

// File: rtl/xreg_bridge_chk.sv
module xreg_bridge_chk
  import xreg_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        wrEn,
  input logic [4:0]  regNum,
  input logic [15:0] wrData,
  input logic        rdEn,
  input logic [15:0] rdData,
  input strobeT      strb,
  input logic [15:0] curPtr
);
  logic [15:0] ctrlShadow;

  always_ff @(posedge clk) begin
    if (rst) ctrlShadow <= '0;
    else if (wrEn && regNum == CTRL_REG) ctrlShadow <= wrData;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> rdData == 16'h0);

  // R2
  ctrl_readback_chk: assert property (@(posedge clk) disable iff (rst)
    (rdEn && !wrEn && regNum == CTRL_REG) |=> rdData == $past(ctrlShadow));

  // R3
  ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
    strb.ptrLoad |=> curPtr == $past(wrData));

  // R4
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!strb.ptrLoad && !strb.ptrIncr && !(wrEn && regNum == CTRL_REG)) |=> $stable(curPtr));

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    strb.ptrIncr |=> curPtr == 16'($past(curPtr) + 16'd1));

  // R6
  read_no_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rdEn && !wrEn && regNum == WIN_REG && ctrlShadow[15:14] != FN_INC_RW) |-> !strb.ptrIncr);

  // R10
  other_reg_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rdEn && !wrEn && regNum != CTRL_REG && regNum != WIN_REG) |=> rdData == 16'h0);

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rdEn || wrEn) |=> $stable(rdData));
endmodule

bind xreg_bridge xreg_bridge_chk u_chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .regNum(regNum), .wrData(wrData),
  .rdEn(rdEn), .rdData(rdData), .strb(strb), .curPtr(curPtr)
);

// File: tb/xreg_bridge_test.sv
`timescale 1ns/1ps
module xreg_bridge_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [4:0]  regNum = '0;
  logic [15:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [15:0] rdData;

  int testCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  xreg_bridge uut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .regNum(regNum),
    .wrData(wrData), .rdEn(rdEn), .rdData(rdData)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [4:0] r, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; regNum = r; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRd(input logic [4:0] r, output logic [15:0] v);
    @(negedge clk);
    rdEn = 1'b1; regNum = r;
    @(negedge clk);
    rdEn = 1'b0;
    v = rdData;
  endtask

  task automatic rdCheck(input string tag, input logic [4:0] r, input logic [15:0] exp);
    logic [15:0] v;
    busRd(r, v);
    check(tag, v, exp);
  endtask

  task automatic t_reset();
    check("R1 rdData after reset", rdData, 16'h0);
    rdCheck("R1 ctrl after reset", 5'd13, 16'h0);
    busWr(5'd13, 16'h401E);
    rdCheck("R1 ext reg after reset", 5'd14, 16'h0);
    busWr(5'd13, 16'h001E);
    rdCheck("R1 pointer after reset", 5'd14, 16'h0);
  endtask

  task automatic t_ctrl();
    busWr(5'd13, 16'hA5FE);
    rdCheck("R2 ctrl readback", 5'd13, 16'hA5FE);
  endtask

  task automatic t_addr();
    busWr(5'd13, 16'h001E);
    busWr(5'd14, 16'h0003);
    rdCheck("R3 address readback", 5'd14, 16'h0003);
  endtask

  task automatic t_noinc();
    busWr(5'd13, 16'h401E);
    busWr(5'd14, 16'h1234);
    rdCheck("R4 data read 1", 5'd14, 16'h1234);
    rdCheck("R4 data read 2", 5'd14, 16'h1234);
    busWr(5'd13, 16'h001E);
    rdCheck("R4 pointer unchanged", 5'd14, 16'h0003);
  endtask

  task automatic t_incrw();
    busWr(5'd13, 16'h001E);
    busWr(5'd14, 16'h0000);
    busWr(5'd13, 16'h801E);
    busWr(5'd14, 16'h1111);
    busWr(5'd14, 16'h2222);
    busWr(5'd13, 16'h001E);
    rdCheck("R5 pointer after writes", 5'd14, 16'h0002);
    busWr(5'd14, 16'h0000);
    busWr(5'd13, 16'h801E);
    rdCheck("R5 read reg0", 5'd14, 16'h1111);
    rdCheck("R5 read reg1", 5'd14, 16'h2222);
    rdCheck("R5 read reg2", 5'd14, 16'h0000);
    rdCheck("R5 read reg3", 5'd14, 16'h1234);
    busWr(5'd13, 16'h001E);
    rdCheck("R5 pointer after reads", 5'd14, 16'h0004);
  endtask

  task automatic t_incw();
    busWr(5'd14, 16'h0000);
    busWr(5'd13, 16'hC01E);
    rdCheck("R6 read no step 1", 5'd14, 16'h1111);
    rdCheck("R6 read no step 2", 5'd14, 16'h1111);
    busWr(5'd14, 16'hAAAA);
    busWr(5'd13, 16'h001E);
    rdCheck("R6 pointer after write", 5'd14, 16'h0001);
  endtask

  task automatic t_wrap();
    busWr(5'd14, 16'hFFFF);
    busWr(5'd13, 16'h801E);
    busWr(5'd14, 16'hBEEF);
    busWr(5'd13, 16'h001E);
    rdCheck("R7 wrap after write", 5'd14, 16'h0000);
    busWr(5'd13, 16'h401E);
    rdCheck("R9 reg0 untouched", 5'd14, 16'hAAAA);
    busWr(5'd13, 16'h001E);
    busWr(5'd14, 16'h0007);
    busWr(5'd13, 16'h401E);
    rdCheck("R9 no alias to reg7", 5'd14, 16'h0000);
    busWr(5'd13, 16'h001E);
    busWr(5'd14, 16'hFFFF);
    busWr(5'd13, 16'h801E);
    rdCheck("R9 out of range reads zero", 5'd14, 16'h0000);
    busWr(5'd13, 16'h001E);
    rdCheck("R7 wrap after read", 5'd14, 16'h0000);
  endtask

  task automatic t_perdev();
    busWr(5'd13, 16'h001F);
    busWr(5'd14, 16'h0005);
    busWr(5'd13, 16'h401F);
    busWr(5'd14, 16'h5555);
    busWr(5'd13, 16'h001E);
    busWr(5'd14, 16'h0005);
    busWr(5'd13, 16'h001F);
    rdCheck("R8 dev31 pointer kept", 5'd14, 16'h0005);
    busWr(5'd13, 16'h001E);
    rdCheck("R8 dev30 pointer", 5'd14, 16'h0005);
    busWr(5'd13, 16'h401E);
    rdCheck("R8 dev30 reg5 untouched", 5'd14, 16'h0000);
    busWr(5'd13, 16'h401F);
    rdCheck("R8 dev31 reg5", 5'd14, 16'h5555);
  endtask

  task automatic t_unimpl();
    busWr(5'd13, 16'h0000);
    busWr(5'd14, 16'h0007);
    rdCheck("R9 unimpl pointer reads zero", 5'd14, 16'h0000);
    busWr(5'd13, 16'h4000);
    busWr(5'd14, 16'h7777);
    rdCheck("R9 unimpl data reads zero", 5'd14, 16'h0000);
    busWr(5'd13, 16'h001E);
    rdCheck("R9 dev30 pointer unaffected", 5'd14, 16'h0005);
    busWr(5'd13, 16'h401E);
    rdCheck("R9 dev30 reg5 unaffected", 5'd14, 16'h0000);
  endtask

  task automatic t_other();
    busWr(5'd13, 16'h401F);
    busWr(5'd0, 16'hFFFF);
    busWr(5'd15, 16'h1234);
    rdCheck("R10 reg0 reads zero", 5'd0, 16'h0000);
    rdCheck("R10 reg15 reads zero", 5'd15, 16'h0000);
    rdCheck("R10 ctrl unaffected", 5'd13, 16'h401F);
    rdCheck("R10 data unaffected", 5'd14, 16'h5555);
  endtask

  task automatic t_timing();
    rdCheck("R11 read value", 5'd14, 16'h5555);
    repeat (3) @(negedge clk);
    check("R11 hold when idle", rdData, 16'h5555);
    @(negedge clk);
    wrEn = 1'b1; rdEn = 1'b1; regNum = 5'd14; wrData = 16'h6666;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    check("R11 read ignored with write", rdData, 16'h5555);
    rdCheck("R11 write taken with read", 5'd14, 16'h6666);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ctrl();
    t_addr();
    t_noinc();
    t_incrw();
    t_incw();
    t_wrap();
    t_perdev();
    t_unimpl();
    t_other();
    t_timing();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end
endmodule